// File: doc/BRIEF.md
# Atomic Swap Memory Sequencer

This block carries out an indivisible exchange between a register value and one memory location on a simple data-memory bus. A request supplies an address, a transfer size (byte or word) and the value to be stored. The block then runs three steps. First comes an internal step with no memory access. Next, a non-sequential read of the location. Last, a non-sequential write of the supplied value to that same location. A lock output stays high across the read and the write, so no other master can get in between them.

The old contents of the location are returned as the result for the destination register. If either memory access reports an abort, the result is flagged invalid and the register must keep its value. An abort on the read means the write is never issued. The block accepts one request at a time. Address, size and write data are captured when a request is accepted and held for the whole exchange.

Top module: `swap_seq`

## Requirements
- R1: While `req_i` is high and the block is idle (`busy_o` low), the request is accepted on that clock edge. During the next cycle the block is in its internal step: `busy_o` is 1, and `mem_req_o` and `mem_lock_o` are both 0.
- R2: In the cycle after the internal step, the block issues a read: `mem_req_o`=1, `mem_we_o`=0, `mem_seq_o`=0, and `mem_addr_o` equals the captured address.
- R3: If the read does not abort, the following cycle is a write to the same address: `mem_req_o`=1, `mem_we_o`=1, `mem_seq_o`=0. `mem_wdata_o` carries the captured data. In a byte swap, the low byte is replicated to all four lanes.
- R4: `mem_lock_o` is 1 in exactly the read and write cycles of a swap, and 0 at all other times.
- R5: `mem_wdata_o` is zero in every cycle that is not a write cycle.
- R6: For a word swap (`size_i`=1), `mem_be_o`=4'b1111 and the result is the full 32-bit read data. For a byte swap (`size_i`=0), `mem_be_o` is one-hot with bit `addr[1:0]` set. The result is read-data byte `addr[1:0]` (bits 8*addr[1:0]+7 down to 8*addr[1:0]), zero-extended to 32 bits.
- R7: If `mem_abort_i` is high in the read cycle, no write cycle follows, the lock drops, and the exchange ends with `done_o`=1 and `res_valid_o`=0.
- R8: If `mem_abort_i` is high in the write cycle, the exchange ends with `done_o`=1 and `res_valid_o`=0.
- R9: `done_o` pulses for exactly one cycle, in the cycle after the last memory access. `res_valid_o` is 1 only together with `done_o`, and only when neither access aborted. In that case `result_o` holds the old memory value.
- R10: Requests presented while `busy_o` is high are ignored. The address and data in use do not change during a swap.
- R11: A synchronous active-high `rst_i` returns the block to idle, with `busy_o`, `mem_req_o`, `mem_lock_o` and `done_o` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Swap request |
| addr_i | input | AW | Swap address |
| size_i | input | 1 | 1 = word, 0 = byte |
| wdata_i | input | 32 | Register value to store |
| busy_o | output | 1 | Swap in progress |
| done_o | output | 1 | One-cycle end pulse |
| res_valid_o | output | 1 | Result may update the register |
| result_o | output | 32 | Old memory contents |
| mem_req_o | output | 1 | Memory access active |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_seq_o | output | 1 | Sequential-access flag (always 0 here) |
| mem_lock_o | output | 1 | Atomic lock |
| mem_addr_o | output | AW | Memory address |
| mem_be_o | output | 4 | Byte enables |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data |
| mem_abort_i | input | 1 | Access abort |

## Verification
The bench builds the block with its default address width of 32. At that width, all four byte lanes can be reached by the address, along with full-width address values. A behavioural model holds a small memory of bytes and predicts every bus output and every result on each clock. The stimulus covers word and byte swaps in every lane, aborts on the read and on the write, and requests raised while busy. It also includes back-to-back requests and a reset in the middle of a swap.

// File: rtl/swap_seq.sv
module swap_seq #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic          size_i,
  input  logic [31:0]   wdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          res_valid_o,
  output logic [31:0]   result_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic          mem_seq_o,
  output logic          mem_lock_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [3:0]    mem_be_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  input  logic          mem_abort_i
);

  typedef enum logic [2:0] {S_IDLE, S_INT, S_RD, S_WR, S_END} st_t;
  st_t st;

  logic [AW-1:0] a_q;
  logic          w_q;
  logic [31:0]   d_q;
  logic [31:0]   old_q;
  logic          ok_q;

  logic [1:0]  lane;
  logic [7:0]  rbyte;

  assign lane  = a_q[1:0];
  assign rbyte = mem_rdata_i[8*lane +: 8];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st    <= S_IDLE;
      a_q   <= '0;
      w_q   <= 1'b0;
      d_q   <= '0;
      old_q <= '0;
      ok_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_i) begin
          st  <= S_INT;
          a_q <= addr_i;
          w_q <= size_i;
          d_q <= wdata_i;
        end
        S_INT: st <= S_RD;
        S_RD: begin
          old_q <= w_q ? mem_rdata_i : {24'd0, rbyte};
          ok_q  <= !mem_abort_i;
          st    <= mem_abort_i ? S_END : S_WR;
        end
        S_WR: begin
          if (mem_abort_i) ok_q <= 1'b0;
          st <= S_END;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = (st != S_IDLE);
  assign done_o      = (st == S_END);
  assign res_valid_o = done_o && ok_q;
  assign result_o    = done_o ? old_q : '0;
  assign mem_req_o   = (st == S_RD) || (st == S_WR);
  assign mem_we_o    = (st == S_WR);
  assign mem_seq_o   = 1'b0;
  assign mem_lock_o  = mem_req_o;
  assign mem_addr_o  = mem_req_o ? a_q : '0;
  assign mem_be_o    = !mem_req_o ? 4'b0000 :
                       w_q ? 4'b1111 : (4'b0001 << lane);
  assign mem_wdata_o = !mem_we_o ? 32'd0 :
                       w_q ? d_q : {4{d_q[7:0]}};

  p_int_quiet_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    (!busy_o && req_i) |=> (busy_o && !mem_req_o && !mem_lock_o));

  p_rd_follows_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_o && !mem_req_o && !done_o) |=> (mem_req_o && !mem_we_o));

  p_wr_after_rd_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (mem_req_o && !mem_we_o && !mem_abort_i) |=>
      (mem_req_o && mem_we_o && $stable(mem_addr_o)));

  p_lock_match_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    mem_lock_o == mem_req_o);

  p_rd_abort_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (mem_req_o && !mem_we_o && mem_abort_i) |=>
      (!mem_req_o && done_o && !res_valid_o));

  p_wr_abort_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (mem_we_o && mem_abort_i) |=> (done_o && !res_valid_o));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> !done_o);

  p_be_onehot_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    mem_req_o |-> ($countones(mem_be_o) == 1 || mem_be_o == 4'b1111));

  p_reset_idle_r11: assert property (@(posedge clk_i)
    rst_i |=> (!busy_o && !mem_req_o && !mem_lock_o && !done_o));

endmodule

// File: tb/swap_seq_tb.sv
module swap_seq_tb_top;
  logic clk = 0, rst = 1;
  always #10 clk = ~clk;

  logic req = 0, size = 0, abort = 0;
  logic [31:0] addr = 0, wdata = 0, rdata = 0;
  logic busy, done, rv, mreq, mwe, mseq, mlock;
  logic [31:0] result, maddr, mwd;
  logic [3:0] mbe;

  swap_seq #(.AW(32)) dut_i (
    .clk_i(clk), .rst_i(rst), .req_i(req), .addr_i(addr), .size_i(size),
    .wdata_i(wdata), .busy_o(busy), .done_o(done), .res_valid_o(rv),
    .result_o(result), .mem_req_o(mreq), .mem_we_o(mwe), .mem_seq_o(mseq),
    .mem_lock_o(mlock), .mem_addr_o(maddr), .mem_be_o(mbe),
    .mem_wdata_o(mwd), .mem_rdata_i(rdata), .mem_abort_i(abort));

  int errs = 0, checks = 0;
  logic [7:0] mem [logic [31:0]];

  // reference model state
  int m_st = 0;
  logic [31:0] m_a, m_d, m_old;
  logic m_w, m_ok;
  logic [31:0] e_rd_word;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s t=%0t actual=%h expected=%h", r, $time, act, exp);
    end
  endtask

  function automatic logic [7:0] rdb(logic [31:0] a);
    return mem.exists(a) ? mem[a] : a[7:0] ^ 8'h5A;
  endfunction

  function automatic logic [31:0] rdw(logic [31:0] a);
    logic [31:0] b = {a[31:2], 2'b00};
    return {rdb(b+3), rdb(b+2), rdb(b+1), rdb(b)};
  endfunction

  // memory model drives read data combinationally
  always_comb rdata = (mreq && !mwe) ? rdw(maddr) : 32'h0;

  // compare on every clock, at negedge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R1 busy", busy, m_st != 0);
      chk("R4 lock", mlock, m_st == 2 || m_st == 3);
      chk("R2 req", mreq, m_st == 2 || m_st == 3);
      chk("R3 we", mwe, m_st == 3);
      chk("R2 seq", mseq, 0);
      chk("R9 done", done, m_st == 4);
      chk("R9 rv", rv, m_st == 4 && m_ok);
      chk("R5 wdata", mwd, m_st == 3 ? (m_w ? m_d : {4{m_d[7:0]}}) : 32'h0);
      if (m_st == 2 || m_st == 3) begin
        chk("R2 addr", maddr, m_a);
        chk("R6 be", mbe, m_w ? 4'hF : 4'b0001 << m_a[1:0]);
      end
      if (m_st == 4 && m_ok) chk("R9 result", result, m_old);
    end
  end

  // model advance at posedge (inputs stable; driven at negedge)
  always @(posedge clk) begin
    if (rst) m_st <= 0;
    else case (m_st)
      0: if (req) begin m_st <= 1; m_a <= addr; m_w <= size; m_d <= wdata; end
      1: m_st <= 2;
      2: begin
        e_rd_word = rdw(m_a);
        m_old <= m_w ? e_rd_word : {24'd0, e_rd_word[8*m_a[1:0] +: 8]};
        m_ok <= !abort;
        m_st <= abort ? 4 : 3;
      end
      3: begin
        if (abort) m_ok <= 0;
        else if (m_w)
          for (int i = 0; i < 4; i++) mem[{m_a[31:2], 2'b00} + i] = m_d[8*i +: 8];
        else mem[m_a] = m_d[7:0];
        m_st <= 4;
      end
      default: m_st <= 0;
    endcase
  end

  // abort generator: ab_rd / ab_wr select the access to abort
  logic ab_rd = 0, ab_wr = 0;
  always_comb abort = (mreq && !mwe && ab_rd) || (mwe && ab_wr);

  task automatic swap(logic [31:0] a, logic s, logic [31:0] d, logic ar, logic aw);
    @(negedge clk);
    req = 1; addr = a; size = s; wdata = d; ab_rd = ar; ab_wr = aw;
    @(negedge clk);
    // R10: change inputs while busy; must be ignored
    addr = ~a; wdata = ~d; size = ~s;
    repeat (4) @(negedge clk);
    req = 0;
  endtask

  initial begin
    fork
      begin #4000000; errs++; checks++; $display("FAIL watchdog"); end
    join_none
    repeat (3) @(negedge clk);
    chk("R11 reset busy", busy, 0);
    chk("R11 reset lock", mlock, 0);
    rst = 0;
    swap(32'h100, 1, 32'hDEADBEEF, 0, 0);
    swap(32'h100, 1, 32'h11223344, 0, 0);   // R9 old = DEADBEEF
    for (int l = 0; l < 4; l++) swap(32'h200 + l, 0, 32'hA0 + l, 0, 0); // R6 lanes
    for (int l = 0; l < 4; l++) swap(32'h200 + l, 0, 32'hB0, 0, 0);
    swap(32'h100, 1, 32'hCAFEF00D, 1, 0);   // R7 read abort
    swap(32'h100, 1, 32'h0BADF00D, 0, 1);   // R8 write abort
    swap(32'h100, 1, 32'h55555555, 0, 0);   // memory unchanged -> 11223344
    swap(32'h203, 0, 32'h77, 1, 0);
    // R11 reset mid-swap
    @(negedge clk); req = 1; addr = 32'h300; size = 1; ab_rd = 0; ab_wr = 0;
    @(negedge clk); req = 0;
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R11 mid reset busy", busy, 0);
    chk("R11 mid reset req", mreq, 0);
    swap(32'h300, 1, 32'h12345678, 0, 0);
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule